// File: doc/BRIEF.md
# Two-Bank Flash Program and Erase Sequencer

This block sits on the host side of a two-bank NOR flash. The flash is reached over a simple synchronous word bus. That bus has an address, write data, read data, a write strobe and a read strobe. The most significant address bit selects the bank. A client hands the sequencer one request at a time: program a word, or erase a sector, a block or a whole bank. The sequencer turns the request into the unlock and command writes the flash expects. It then watches the status bits of the flash until the internal operation ends, and closes the request with a single done pulse that may carry an error.

Before a program, the block reads the target word and refuses to write unless the word is fully erased. Completion is detected either by watching a status bit that alternates on every read, or by watching a bit that shows the complement of the final value until the operation ends. The client picks the method for each request. An apparent finish is never trusted on its own. The location is read twice more, and both reads must return the final expected word. A parameterised limit on status reads ends a hung operation with an error.

Top module: `fps_seq`

## Requirements
- R1: While reset is high and directly after it, busy, done, error, the write strobe and the read strobe are all low.
- R2: A program request (op code 2'b00) writes four words in this order: 0xAA at offset 0x5555, 0x55 at offset 0x2AAA, 0xA0 at offset 0x5555, then the request data at the target offset. The bank bit (address MSB) equals the requested bank in every word, and command words carry the code in data bits [7:0] with the upper bits zero.
- R3: Erase requests write six words: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, then a final word. The final word is 0x30 at the target offset for a sector erase (op 2'b01), 0x50 at the target offset for a block erase (op 2'b10), and 0x10 at offset 0x5555 for a bank erase (op 2'b11).
- R4: A program request first reads the target word. If that word is not all ones, the request ends with error set and no write strobe is issued.
- R5: In toggle mode (poll select 0), the target location is read repeatedly. The finish appears when two consecutive reads return the same bit 6.
- R6: In data-poll mode (poll select 1), the finish appears on the first read whose bit 7 equals the expected final bit 7. That bit is the data's bit 7 for a program and 1 for an erase.
- R7: After an apparent finish, two further reads are made. The request succeeds only if both return the expected final word: the request data for a program, all ones for an erase. Otherwise the request ends with error.
- R8: If POLL_LIMIT status reads pass without an apparent finish, the request ends with error after exactly POLL_LIMIT status reads.
- R9: Every accepted request ends with done high for exactly one cycle. Error is high only in that cycle.
- R10: A start is accepted only while the block is idle. A start that arrives while busy has no effect.
- R11: Read data is taken one cycle after the read strobe. The write and read strobes are never high together, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse for a new request |
| req_op | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 bank erase |
| req_bank | input | 1 | Target bank |
| req_addr | input | ADDR_W-1 | Word offset inside the bank |
| req_data | input | DATA_W | Word to program |
| req_poll_data | input | 1 | 1 selects data polling, 0 selects toggle polling |
| busy | output | 1 | High from acceptance to the done cycle inclusive |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |
| fl_addr | output | ADDR_W | Flash word address, MSB is the bank |
| fl_wdata | output | DATA_W | Flash write data |
| fl_we | output | 1 | Flash write strobe, one word per cycle |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | DATA_W | Flash read data, valid the cycle after fl_re |

## Verification
The assertions take three things for granted. The flash answers every read strobe with data on the very next cycle. A request start is a single-cycle pulse. Reset is held long enough to clear the state register. The bench keeps within these conditions by placing a behavioural flash model on the bus that registers its read data on the strobe edge, and by driving each start for one cycle only, including the intruding start sent in mid-operation. The model can be told to stay busy forever or to store a wrong word, so the timeout and confirm-read failure paths are reached under those same input conditions.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        OP_PROG      = 2'b00,
        OP_ERS_SECT  = 2'b01,
        OP_ERS_BLK   = 2'b10,
        OP_ERS_BANK  = 2'b11
    } fps_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_RD,
        ST_PRE_WT,
        ST_CMD,
        ST_POLL_RD,
        ST_POLL_WT,
        ST_CONF_RD,
        ST_CONF_WT,
        ST_FIN
    } fps_state_e;

    // unlock offsets inside a bank
    localparam logic [14:0] UNLK_OFF_A = 15'h5555;
    localparam logic [14:0] UNLK_OFF_B = 15'h2AAA;

    // command codes, placed on the low data byte
    localparam logic [7:0] CODE_KEY_A   = 8'hAA;
    localparam logic [7:0] CODE_KEY_B   = 8'h55;
    localparam logic [7:0] CODE_PROG    = 8'hA0;
    localparam logic [7:0] CODE_ERASE   = 8'h80;
    localparam logic [7:0] CODE_SECT    = 8'h30;
    localparam logic [7:0] CODE_BLK     = 8'h50;
    localparam logic [7:0] CODE_BANK    = 8'h10;

    // index of the final command word for an operation
    function automatic logic [2:0] last_index(fps_op_e op);
        return (op == OP_PROG) ? 3'd3 : 3'd5;
    endfunction

endpackage

// File: rtl/fps_cmd_gen.sv
module fps_cmd_gen
    import fps_pkg::*;
#(
    parameter int OFF_W  = 19,
    parameter int DATA_W = 16
) (
    input  fps_op_e             op,
    input  logic [2:0]          idx,
    input  logic [OFF_W-1:0]    tgt,
    input  logic [DATA_W-1:0]   data,
    output logic [OFF_W-1:0]    off,
    output logic [DATA_W-1:0]   wdata,
    output logic                last
);
    localparam logic [OFF_W-1:0] OFF_A = OFF_W'(UNLK_OFF_A);
    localparam logic [OFF_W-1:0] OFF_B = OFF_W'(UNLK_OFF_B);

    logic [7:0] code;
    logic       full_word;

    always_comb begin
        off       = OFF_A;
        code      = CODE_KEY_A;
        full_word = 1'b0;
        case (idx)
            3'd0: begin off = OFF_A; code = CODE_KEY_A; end
            3'd1: begin off = OFF_B; code = CODE_KEY_B; end
            3'd2: begin
                off  = OFF_A;
                code = (op == OP_PROG) ? CODE_PROG : CODE_ERASE;
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    off       = tgt;
                    full_word = 1'b1;
                end else begin
                    off  = OFF_A;
                    code = CODE_KEY_A;
                end
            end
            3'd4: begin off = OFF_B; code = CODE_KEY_B; end
            default: begin
                case (op)
                    OP_ERS_SECT: begin off = tgt;   code = CODE_SECT; end
                    OP_ERS_BLK:  begin off = tgt;   code = CODE_BLK;  end
                    default:     begin off = OFF_A; code = CODE_BANK; end
                endcase
            end
        endcase
    end

    assign wdata = full_word ? data : {{(DATA_W-8){1'b0}}, code};
    assign last  = (idx == last_index(op));

endmodule

// File: rtl/fps_status_eval.sv
module fps_status_eval (
    input  logic use_data_poll,
    input  logic rd_b7,
    input  logic rd_b6,
    input  logic exp_b7,
    input  logic prev_b6,
    input  logic have_prev,
    output logic finished
);
    logic toggle_still;
    logic data_match;

    assign toggle_still = have_prev && (rd_b6 == prev_b6);
    assign data_match   = (rd_b7 == exp_b7);
    assign finished     = use_data_poll ? data_match : toggle_still;

endmodule

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIM);

endmodule

// File: rtl/fps_seq.sv
module fps_seq
    import fps_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int POLL_LIMIT = 4096
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_start,
    input  logic [1:0]          req_op,
    input  logic                req_bank,
    input  logic [ADDR_W-2:0]   req_addr,
    input  logic [DATA_W-1:0]   req_data,
    input  logic                req_poll_data,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic [ADDR_W-1:0]   fl_addr,
    output logic [DATA_W-1:0]   fl_wdata,
    output logic                fl_we,
    output logic                fl_re,
    input  logic [DATA_W-1:0]   fl_rdata
);
    localparam int OFF_W = ADDR_W - 1;

    fps_state_e         st;
    fps_op_e            op_q;
    logic               bank_q;
    logic [OFF_W-1:0]   tgt_q;
    logic [DATA_W-1:0]  data_q;
    logic               mode_q;
    logic [2:0]         idx_q;
    logic               prev_b6_q;
    logic               have_prev_q;
    logic               conf_q;
    logic               err_q;

    logic [OFF_W-1:0]   cmd_off;
    logic [DATA_W-1:0]  cmd_wdata;
    logic               cmd_last;
    logic               poll_fin;
    logic               poll_expired;
    logic [DATA_W-1:0]  exp_word;

    assign exp_word = (op_q == OP_PROG) ? data_q : '1;

    fps_cmd_gen #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_cmd (
        .op    (op_q),
        .idx   (idx_q),
        .tgt   (tgt_q),
        .data  (data_q),
        .off   (cmd_off),
        .wdata (cmd_wdata),
        .last  (cmd_last)
    );

    fps_status_eval u_eval (
        .use_data_poll (mode_q),
        .rd_b7         (fl_rdata[7]),
        .rd_b6         (fl_rdata[6]),
        .exp_b7        (exp_word[7]),
        .prev_b6       (prev_b6_q),
        .have_prev     (have_prev_q),
        .finished      (poll_fin)
    );

    fps_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (st == ST_IDLE),
        .tick    (st == ST_POLL_RD),
        .expired (poll_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            op_q        <= OP_PROG;
            bank_q      <= 1'b0;
            tgt_q       <= '0;
            data_q      <= '0;
            mode_q      <= 1'b0;
            idx_q       <= '0;
            prev_b6_q   <= 1'b0;
            have_prev_q <= 1'b0;
            conf_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_start) begin
                        op_q        <= fps_op_e'(req_op);
                        bank_q      <= req_bank;
                        tgt_q       <= req_addr;
                        data_q      <= req_data;
                        mode_q      <= req_poll_data;
                        idx_q       <= '0;
                        err_q       <= 1'b0;
                        have_prev_q <= 1'b0;
                        st <= (fps_op_e'(req_op) == OP_PROG) ? ST_PRE_RD : ST_CMD;
                    end
                end
                ST_PRE_RD: st <= ST_PRE_WT;
                ST_PRE_WT: begin
                    if (fl_rdata == '1) begin
                        st <= ST_CMD;
                    end else begin
                        err_q <= 1'b1;
                        st    <= ST_FIN;
                    end
                end
                ST_CMD: begin
                    if (cmd_last) begin
                        st <= ST_POLL_RD;
                    end else begin
                        idx_q <= idx_q + 3'd1;
                    end
                end
                ST_POLL_RD: st <= ST_POLL_WT;
                ST_POLL_WT: begin
                    if (poll_fin) begin
                        conf_q <= 1'b0;
                        st     <= ST_CONF_RD;
                    end else if (poll_expired) begin
                        err_q <= 1'b1;
                        st    <= ST_FIN;
                    end else begin
                        prev_b6_q   <= fl_rdata[6];
                        have_prev_q <= 1'b1;
                        st          <= ST_POLL_RD;
                    end
                end
                ST_CONF_RD: st <= ST_CONF_WT;
                ST_CONF_WT: begin
                    if (fl_rdata != exp_word) begin
                        err_q <= 1'b1;
                        st    <= ST_FIN;
                    end else if (conf_q) begin
                        st <= ST_FIN;
                    end else begin
                        conf_q <= 1'b1;
                        st     <= ST_CONF_RD;
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_FIN);
    assign error    = (st == ST_FIN) && err_q;
    assign fl_we    = (st == ST_CMD);
    assign fl_re    = (st == ST_PRE_RD) || (st == ST_POLL_RD) || (st == ST_CONF_RD);
    assign fl_addr  = {bank_q, (st == ST_CMD) ? cmd_off : tgt_q};
    assign fl_wdata = (st == ST_CMD) ? cmd_wdata : '0;

endmodule

// File: rtl/fps_seq_chk.sv
module fps_seq_chk (
    input logic clk,
    input logic rst,
    input logic req_start,
    input logic busy,
    input logic done,
    input logic error,
    input logic fl_we,
    input logic fl_re
);
    // R11: strobes are exclusive
    a_r11_we_re_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    // R11: no bus activity while idle
    a_r11_strobe_needs_busy: assert property (@(posedge clk) disable iff (rst)
        (fl_we || fl_re) |-> busy);

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: error only in the done cycle
    a_r9_error_with_done: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    // R10: busy begins only after a start
    a_r10_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_start));

    // R9: done ends the busy period
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
endmodule

bind fps_seq fps_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_start (req_start),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .fl_we     (fl_we),
    .fl_re     (fl_re)
);

// File: tb/fps_seq_tb.sv
module fps_seq_tb_top;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int LIMIT = 64;
    localparam int BUSY  = 25;
    localparam int SECT  = 64;
    localparam int BLK   = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_start = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic          req_bank = 1'b0;
    logic [AW-2:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_poll_data = 1'b0;
    logic          busy, done, error;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic          fl_we, fl_re;
    logic [DW-1:0] fl_rdata;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    fps_seq #(.ADDR_W(AW), .DATA_W(DW), .POLL_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
        .req_bank(req_bank), .req_addr(req_addr), .req_data(req_data),
        .req_poll_data(req_poll_data), .busy(busy), .done(done), .error(error),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata)
    );

    // ---------------- behavioural flash ----------------
    logic [DW-1:0] mem [0:(1<<AW)-1];
    int            step;
    int            bsy;
    logic          stk, tog, pbank, pexp7;
    logic          stuck_arm = 1'b0;
    logic          corrupt_arm = 1'b0;

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = '1;
    end

    always @(posedge clk) begin
        if (rst) begin
            step <= 0; bsy <= 0; stk <= 1'b0; tog <= 1'b0;
            pbank <= 1'b0; pexp7 <= 1'b0; fl_rdata <= '0;
        end else begin
            if (bsy > 0) bsy <= bsy - 1;
            if (!stuck_arm) stk <= 1'b0;
            if (fl_re) begin
                if ((bsy > 0 || stk) && fl_addr[AW-1] == pbank) begin
                    fl_rdata <= {8'h00, ~pexp7, tog, 6'h00};
                    tog <= ~tog;
                end else begin
                    fl_rdata <= mem[fl_addr];
                end
            end
            if (fl_we && bsy == 0 && !stk) begin
                case (step)
                    0: step <= (fl_addr[14:0] == 15'h5555 && fl_wdata[7:0] == 8'hAA) ? 1 : 0;
                    1: step <= (fl_addr[14:0] == 15'h2AAA && fl_wdata[7:0] == 8'h55) ? 2 : 0;
                    2: begin
                        if (fl_addr[14:0] == 15'h5555 && fl_wdata[7:0] == 8'hA0) step <= 6;
                        else if (fl_addr[14:0] == 15'h5555 && fl_wdata[7:0] == 8'h80) step <= 3;
                        else step <= 0;
                    end
                    3: step <= (fl_addr[14:0] == 15'h5555 && fl_wdata[7:0] == 8'hAA) ? 4 : 0;
                    4: step <= (fl_addr[14:0] == 15'h2AAA && fl_wdata[7:0] == 8'h55) ? 5 : 0;
                    5: begin
                        step <= 0;
                        if (fl_wdata[7:0] == 8'h30 || fl_wdata[7:0] == 8'h50 ||
                            (fl_wdata[7:0] == 8'h10 && fl_addr[14:0] == 15'h5555)) begin
                            bsy <= BUSY; pbank <= fl_addr[AW-1]; pexp7 <= 1'b1; stk <= stuck_arm;
                            if (fl_wdata[7:0] == 8'h30)
                                for (int i = 0; i < SECT; i++) mem[{fl_addr[15:6], 6'(i)}] <= '1;
                            else if (fl_wdata[7:0] == 8'h50)
                                for (int i = 0; i < BLK; i++) mem[{fl_addr[15:10], 10'(i)}] <= '1;
                            else
                                for (int i = 0; i < (1 << (AW-1)); i++) mem[{fl_addr[15], 15'(i)}] <= '1;
                        end
                    end
                    6: begin
                        logic [DW-1:0] nv;
                        step <= 0;
                        nv = mem[fl_addr] & fl_wdata;
                        if (corrupt_arm) nv = nv ^ 16'h0001;
                        mem[fl_addr] <= nv;
                        bsy <= BUSY; pbank <= fl_addr[AW-1]; pexp7 <= nv[7]; stk <= stuck_arm;
                    end
                    default: step <= 0;
                endcase
            end
        end
    end

    // ---------------- bus monitor ----------------
    logic [DW-1:0] log_a [0:7];
    logic [DW-1:0] log_d [0:7];
    int wr_n = 0, rd_n = 0, done_n = 0, viol = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (fl_we) begin
                if (wr_n < 8) begin log_a[wr_n] = fl_addr; log_d[wr_n] = fl_wdata; end
                wr_n = wr_n + 1;
            end
            if (fl_re) rd_n = rd_n + 1;
            if (done) done_n = done_n + 1;
            if (fl_we && fl_re) viol = viol + 1;
            if ((fl_we || fl_re) && !busy) viol = viol + 1;
            if (error && !done) viol = viol + 1;
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cmd(int op, int idx, logic b, logic [14:0] a, logic [15:0] d);
        logic [14:0] o;
        logic [15:0] w;
        case (idx)
            0: begin o = 15'h5555; w = 16'h00AA; end
            1: begin o = 15'h2AAA; w = 16'h0055; end
            2: begin o = 15'h5555; w = (op == 0) ? 16'h00A0 : 16'h0080; end
            3: begin
                if (op == 0) begin o = a; w = d; end
                else begin o = 15'h5555; w = 16'h00AA; end
            end
            4: begin o = 15'h2AAA; w = 16'h0055; end
            default: begin
                if (op == 1) begin o = a; w = 16'h0030; end
                else if (op == 2) begin o = a; w = 16'h0050; end
                else begin o = 15'h5555; w = 16'h0010; end
            end
        endcase
        return {b, o, w};
    endfunction

    task automatic run_op(input int op, input logic b, input logic [14:0] a, input logic [15:0] d,
                          input logic m, input bit intrude, output logic got_err);
        int n;
        @(negedge clk);
        wr_n = 0; rd_n = 0; done_n = 0;
        req_op = 2'(op); req_bank = b; req_addr = a; req_data = d; req_poll_data = m;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        n = 0;
        if (intrude) begin
            repeat (6) @(negedge clk);
            req_op = 2'b00; req_addr = a + 15'd1; req_data = 16'h1111; req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        while (!done && n < 3000) begin
            @(negedge clk);
            n = n + 1;
        end
        got_err = error;
        chk(done === 1'b1, "R9 done arrives", done, 1);
        @(negedge clk);
        chk(done === 1'b0 && error === 1'b0, "R9 done one cycle", {done, error}, 0);
    endtask

    task automatic chk_seq(input int op, input logic b, input logic [14:0] a, input logic [15:0] d, input string tag);
        int len;
        bit ok;
        len = (op == 0) ? 4 : 6;
        chk(wr_n == len, {tag, " write count"}, wr_n, len);
        for (int i = 0; i < len && i < wr_n; i++) begin
            logic [31:0] e;
            e = exp_cmd(op, i, b, a, d);
            ok = ({log_a[i], log_d[i]} == e);
            chk(ok, {tag, " command word"}, {log_a[i], log_d[i]}, e);
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic e;
        logic [14:0] a, base;
        logic [15:0] d;

        repeat (5) @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0 && fl_we == 0 && fl_re == 0,
            "R1 in reset", {busy, done, error, fl_we, fl_re}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && fl_we == 0 && fl_re == 0,
            "R1 after reset", {busy, done, fl_we, fl_re}, 0);

        // program sweep: banks x poll modes x data patterns
        for (int b = 0; b < 2; b++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 4; k++) begin
                    a = 15'(100 + k * 37 + b * 5 + m * 600);
                    d = 16'(16'h0A5A + k * 16'h0135 + m * 16'h0080 + b * 16'h0100);
                    run_op(0, b[0], a, d, m[0], 1'b0, e);
                    chk(e == 0, m ? "R6 data-poll program ok" : "R5 toggle program ok", e, 0);
                    chk_seq(0, b[0], a, d, "R2 program");
                    chk(mem[{b[0], a}] == d, "R7 programmed word", mem[{b[0], a}], d);
                    chk(rd_n >= 4, "R7 precheck plus confirm reads", rd_n, 4);
                end
            end
        end

        // sector and block erase, both modes
        for (int op = 1; op < 3; op++) begin
            for (int m = 0; m < 2; m++) begin
                int sz;
                sz = (op == 1) ? SECT : BLK;
                a = (op == 1) ? 15'(15'h0A45 + m * 15'h0200) : 15'(15'h2345 + m * 15'h1000);
                base = a & ~15'(sz - 1);
                run_op(0, 1'b1, base - 15'd1, 16'hBEEF, 1'b0, 1'b0, e);
                run_op(0, 1'b1, base + 15'(sz), 16'h3C3C, 1'b1, 1'b0, e);
                run_op(0, 1'b1, a, 16'h0000, 1'b1, 1'b0, e);
                run_op(op, 1'b1, a, 16'h0000, m[0], 1'b0, e);
                chk(e == 0, "R3 erase ok", e, 0);
                chk_seq(op, 1'b1, a, 16'h0000, "R3 erase");
                chk(mem[{1'b1, a}] == 16'hFFFF && mem[{1'b1, base}] == 16'hFFFF &&
                    mem[{1'b1, base + 15'(sz - 1)}] == 16'hFFFF, "R3 region erased", mem[{1'b1, a}], 16'hFFFF);
                chk(mem[{1'b1, base - 15'd1}] == 16'hBEEF && mem[{1'b1, base + 15'(sz)}] == 16'h3C3C,
                    "R3 neighbours kept", mem[{1'b1, base - 15'd1}], 16'hBEEF);
            end
        end

        // bank erase, both modes
        for (int m = 0; m < 2; m++) begin
            run_op(0, 1'b0, 15'h1234, 16'h0F0F, 1'b0, 1'b0, e);
            run_op(0, 1'b1, 15'(15'h7000 + m), 16'h5AA5, 1'b0, 1'b0, e);
            run_op(3, 1'b0, 15'h0000, 16'h0000, m[0], 1'b0, e);
            chk(e == 0, m ? "R6 bank erase ok" : "R5 bank erase ok", e, 0);
            chk_seq(3, 1'b0, 15'h0000, 16'h0000, "R3 bank erase");
            chk(mem[{1'b0, 15'h1234}] == 16'hFFFF && mem[16'h0000] == 16'hFFFF && mem[16'h7FFF] == 16'hFFFF,
                "R3 bank erased", mem[{1'b0, 15'h1234}], 16'hFFFF);
            chk(mem[{1'b1, 15'(15'h7000 + m)}] == 16'h5AA5, "R3 other bank kept",
                mem[{1'b1, 15'(15'h7000 + m)}], 16'h5AA5);
        end

        // precheck refuses a non-erased word
        run_op(0, 1'b0, 15'd200, 16'h1111, 1'b0, 1'b0, e);
        run_op(0, 1'b0, 15'd200, 16'h2222, 1'b1, 1'b0, e);
        chk(e == 1, "R4 precheck error", e, 1);
        chk(wr_n == 0, "R4 no writes", wr_n, 0);
        chk(rd_n == 1, "R4 single read", rd_n, 1);
        chk(mem[{1'b0, 15'd200}] == 16'h1111, "R4 word kept", mem[{1'b0, 15'd200}], 16'h1111);

        // confirm reads catch a wrong stored word
        for (int m = 0; m < 2; m++) begin
            corrupt_arm = 1'b1;
            run_op(0, 1'b1, 15'(300 + m), 16'h5A5A, m[0], 1'b0, e);
            corrupt_arm = 1'b0;
            chk(e == 1, "R7 confirm mismatch error", e, 1);
        end

        // timeout on a flash that never finishes
        for (int m = 0; m < 2; m++) begin
            stuck_arm = 1'b1;
            run_op(1, 1'b0, 15'd400, 16'h0000, m[0], 1'b0, e);
            chk(e == 1, "R8 timeout error", e, 1);
            chk(rd_n == LIMIT, "R8 status read count", rd_n, LIMIT);
            stuck_arm = 1'b0;
            repeat (4) @(negedge clk);
        end

        // start while busy is ignored
        run_op(0, 1'b0, 15'd500, 16'h4321, 1'b0, 1'b1, e);
        repeat (40) @(negedge clk);
        chk(e == 0, "R10 first request ok", e, 0);
        chk(done_n == 1, "R10 single done", done_n, 1);
        chk(wr_n == 4, "R10 no extra writes", wr_n, 4);
        chk(busy == 0, "R10 idle afterwards", busy, 0);
        chk(mem[{1'b0, 15'd501}] == 16'hFFFF, "R10 intruder not programmed",
            mem[{1'b0, 15'd501}], 16'hFFFF);

        chk(viol == 0, "R11 bus rules", viol, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule